// File: doc/BRIEF.md
# Fully Associative Tag Match

This block is the lookup half of a fully associative cache. The cache presents a block number, and the block compares it against the tag held in every line at once. There is no index field: the whole block number is the tag, so any block may sit in any line. The result is a hit flag and the number of the line that holds the block. The data array, the victim choice and the path to main memory live in neighbouring blocks, which take the line number from here.

A write port loads a tag into a chosen line and marks that line valid. A separate port clears the valid bit of a line by index. A free-line output names the lowest unused line, so an allocator can fill it without a search of its own. Lookup is purely combinational from the tag input and has no handshake. The lookup, write and invalidate pins are all plain control and status signals with no back-pressure. The write and invalidate ports apply on every rising clock edge at which they are enabled.

Top module: `fa_tag_match`

## Requirements
- R1: After reset every line is invalid: `hit` and `multi_hit` are 0, `hit_line` is 0, `free_valid` is 1 and `free_line` is 0.
- R2: When a valid line holds a tag equal to `look_tag`, `hit` is 1 and `hit_line` gives that line's index in the same cycle, with no clock edge between the tag and the result.
- R3: When no valid line matches, `hit` is 0, `multi_hit` is 0 and `hit_line` is 0.
- R4: When several valid lines match, `hit_line` gives the lowest matching index and `multi_hit` is 1. With exactly one match, `multi_hit` is 0.
- R5: With `wr_en` high, the rising edge stores `wr_tag` in line `wr_line` and marks it valid. During the cycle of the write itself, the lookup still reflects the old contents.
- R6: With `inv_en` high, the rising edge clears the valid bit of line `inv_line`. An invalid line never matches, even when its stored tag equals `look_tag`.
- R7: `free_line` is the lowest index whose line is invalid, and `free_valid` is 1. When every line is valid, `free_valid` is 0 and `free_line` is 0.
- R8: When a write and an invalidate target the same line on the same edge, the write wins and the line ends valid with the new tag.
- R9: All `TAG_W` bits take part in the compare. A tag that differs from a stored tag only in bit 0, or only in bit `TAG_W-1`, misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; invalidates all lines |
| look_tag | input | TAG_W | Block number to look up |
| hit | output | 1 | At least one valid line holds `look_tag` |
| hit_line | output | IDX_W | Lowest matching line; 0 on a miss |
| multi_hit | output | 1 | More than one valid line matches (error case) |
| wr_en | input | 1 | Load `wr_tag` into `wr_line` at the next edge |
| wr_line | input | IDX_W | Line to load |
| wr_tag | input | TAG_W | Tag to load |
| inv_en | input | 1 | Invalidate `inv_line` at the next edge |
| inv_line | input | IDX_W | Line to invalidate |
| free_valid | output | 1 | Some line is invalid |
| free_line | output | IDX_W | Lowest invalid line; 0 when all lines are valid |

## Verification
The lookup outputs `hit`, `hit_line` and `multi_hit` are due in the same cycle that `look_tag` changes, because no register lies between them. The effect of a write or an invalidate appears on the lookup and free-line outputs only after the next rising edge. The bench changes its inputs 1 ns after a rising edge and compares at the following falling edge. For a write, this means the old contents are checked in the cycle of the write and the new contents in the cycle after it. The expected values come from a small line-by-line model in the bench, which is updated at the same edge as the design.

// File: rtl/fatm_pkg.sv
`timescale 1ns/1ps
package fatm_pkg;
  localparam int unsigned DEF_LINES = 16;
  localparam int unsigned DEF_TAG_W = 22;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_DROP = 2'd2
  } line_act_e;
endpackage

// File: rtl/fatm_store.sv
`timescale 1ns/1ps
module fatm_store
  import fatm_pkg::*;
#(
  parameter int LINES = DEF_LINES,
  parameter int TAG_W = DEF_TAG_W,
  parameter int IDX_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_line,
  input  logic [TAG_W-1:0]             wr_tag,
  input  logic                         inv_en,
  input  logic [IDX_W-1:0]             inv_line,
  output logic [LINES-1:0]             valid_o,
  output logic [LINES-1:0][TAG_W-1:0]  tags_o
);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    line_act_e act;

    // a load beats a drop aimed at the same line (R8)
    always_comb begin
      if (wr_en && wr_line == IDX_W'(i))        act = ACT_LOAD;
      else if (inv_en && inv_line == IDX_W'(i)) act = ACT_DROP;
      else                                      act = ACT_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_o[i] <= 1'b0;
        tags_o[i]  <= '0;
      end else begin
        case (act)
          ACT_LOAD: begin
            valid_o[i] <= 1'b1;
            tags_o[i]  <= wr_tag;
          end
          ACT_DROP: valid_o[i] <= 1'b0;
          default:  ;
        endcase
      end
    end

    // lines not addressed keep their state (R5, R6)
    p_untouched_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_en && wr_line == IDX_W'(i)) && !(inv_en && inv_line == IDX_W'(i)))
      |=> ($stable(valid_o[i]) && $stable(tags_o[i])));
  end

  p_load_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (valid_o[$past(wr_line)] && tags_o[$past(wr_line)] == $past(wr_tag)));

  p_drop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !(wr_en && wr_line == inv_line)) |=> !valid_o[$past(inv_line)]);

endmodule

// File: rtl/fatm_compare.sv
`timescale 1ns/1ps
module fatm_compare
  import fatm_pkg::*;
#(
  parameter int LINES = DEF_LINES,
  parameter int TAG_W = DEF_TAG_W
) (
  input  logic [TAG_W-1:0]             look_tag,
  input  logic [LINES-1:0]             valid_i,
  input  logic [LINES-1:0][TAG_W-1:0]  tags_i,
  output logic [LINES-1:0]             match_o
);

  // one full-width comparator per line, all evaluated together (R2, R9)
  for (genvar i = 0; i < LINES; i++) begin : g_cmp
    assign match_o[i] = valid_i[i] && (tags_i[i] == look_tag);
  end

endmodule

// File: rtl/fatm_prio.sv
`timescale 1ns/1ps
module fatm_prio #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);

  // lowest set request wins; index is 0 when nothing is set
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/fa_tag_match.sv
`timescale 1ns/1ps
module fa_tag_match
  import fatm_pkg::*;
#(
  parameter int  LINES = DEF_LINES,
  parameter int  TAG_W = DEF_TAG_W,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] look_tag,
  output logic             hit,
  output logic [IDX_W-1:0] hit_line,
  output logic             multi_hit,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_line,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_line,
  output logic             free_valid,
  output logic [IDX_W-1:0] free_line
);

  logic [LINES-1:0]            valid_q;
  logic [LINES-1:0][TAG_W-1:0] tags_q;
  logic [LINES-1:0]            match_vec;
  logic [LINES-1:0]            empty_vec;

  fatm_store #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_line (wr_line),
    .wr_tag  (wr_tag),
    .inv_en  (inv_en),
    .inv_line(inv_line),
    .valid_o (valid_q),
    .tags_o  (tags_q)
  );

  fatm_compare #(.LINES(LINES), .TAG_W(TAG_W)) i_compare (
    .look_tag(look_tag),
    .valid_i (valid_q),
    .tags_i  (tags_q),
    .match_o (match_vec)
  );

  fatm_prio #(.N(LINES), .IDX_W(IDX_W)) i_hit_enc (
    .req_i(match_vec),
    .any_o(hit),
    .idx_o(hit_line)
  );

  // two or more bits set: clearing the lowest one leaves something
  assign multi_hit = |(match_vec & (match_vec - LINES'(1)));

  assign empty_vec = ~valid_q;

  fatm_prio #(.N(LINES), .IDX_W(IDX_W)) i_free_enc (
    .req_i(empty_vec),
    .any_o(free_valid),
    .idx_o(free_line)
  );

  p_hit_is_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (match_vec[hit_line] && valid_q[hit_line] && tags_q[hit_line] == look_tag));

  p_miss_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_line == '0 && !multi_hit && match_vec == '0));

  p_lowest_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((match_vec & ((LINES'(1) << hit_line) - LINES'(1))) == '0));

  p_multi_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    multi_hit == ($countones(match_vec) > 1));

  p_free_is_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid |-> !valid_q[free_line]);

  p_full_no_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !free_valid |-> (valid_q == '1 && free_line == '0));

endmodule

// File: tb/test_fa_tag_match.sv
`timescale 1ns/1ps
module test_fa_tag_match;
  localparam int LINES = 16;
  localparam int TAG_W = 22;
  localparam int IDX_W = 4;

  typedef struct {
    string            req;
    logic [TAG_W-1:0] tag;
    logic             hit;
    logic [IDX_W-1:0] line;
    logic             multi;
    logic             fv;
    logic [IDX_W-1:0] fl;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [TAG_W-1:0] look_tag = '0;
  logic             hit, multi_hit, free_valid;
  logic [IDX_W-1:0] hit_line, free_line;
  logic             wr_en = 1'b0;
  logic [IDX_W-1:0] wr_line = '0;
  logic [TAG_W-1:0] wr_tag = '0;
  logic             inv_en = 1'b0;
  logic [IDX_W-1:0] inv_line = '0;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  logic             mv [LINES];
  logic [TAG_W-1:0] mt [LINES];
  exp_t             sb [$];

  always #2 clk = ~clk;

  fa_tag_match #(.LINES(LINES), .TAG_W(TAG_W)) i_fa_tag_match (
    .clk(clk), .rst_n(rst_n), .look_tag(look_tag), .hit(hit),
    .hit_line(hit_line), .multi_hit(multi_hit), .wr_en(wr_en),
    .wr_line(wr_line), .wr_tag(wr_tag), .inv_en(inv_en),
    .inv_line(inv_line), .free_valid(free_valid), .free_line(free_line)
  );

  // expected lookup and free-line results from the line model
  function automatic exp_t predict(input logic [TAG_W-1:0] t, input string r);
    exp_t e;
    e.req = r; e.tag = t; e.hit = 0; e.line = '0; e.multi = 0;
    e.fv = 0; e.fl = '0;
    for (int i = 0; i < LINES; i++) begin
      if (mv[i] && mt[i] == t) begin
        if (!e.hit) begin e.hit = 1; e.line = IDX_W'(i); end
        else e.multi = 1;
      end
    end
    for (int i = LINES - 1; i >= 0; i--) begin
      if (!mv[i]) begin e.fv = 1; e.fl = IDX_W'(i); end
    end
    return e;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < LINES; i++) begin mv[i] = 0; mt[i] = '0; end
  endtask

  task automatic push_wait(input logic [TAG_W-1:0] t, input string r);
    sb.push_back(predict(t, r));
    wait (sb.size() == 0);
  endtask

  task automatic look(input logic [TAG_W-1:0] t, input string r);
    @(posedge clk); #1;
    look_tag = t;
    push_wait(t, r);
  endtask

  // drive both ports for one edge; the model follows the same priority
  task automatic update(input bit we, input int wl, input logic [TAG_W-1:0] wt,
                        input bit ie, input int il);
    @(posedge clk); #1;
    wr_en = we; wr_line = IDX_W'(wl); wr_tag = wt;
    inv_en = ie; inv_line = IDX_W'(il);
    @(posedge clk);
    if (ie) mv[il] = 0;
    if (we) begin mv[wl] = 1; mt[wl] = wt; end
    #1;
    wr_en = 0; inv_en = 0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 0;
    model_clear();
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  // monitor: compares at the falling edge after each pushed item
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_checks++;
        if (hit !== e.hit || hit_line !== e.line || multi_hit !== e.multi ||
            free_valid !== e.fv || free_line !== e.fl) begin
          n_fail++;
          $display("FAIL %s tag=%h got hit=%b line=%0d multi=%b fv=%b fl=%0d exp hit=%b line=%0d multi=%b fv=%b fl=%0d",
                   e.req, e.tag, hit, hit_line, multi_hit, free_valid, free_line,
                   e.hit, e.line, e.multi, e.fv, e.fl);
        end
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired got running exp finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  localparam logic [TAG_W-1:0] TA = 22'h3ABCDE;
  localparam logic [TAG_W-1:0] TB = 22'h012345;

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: empty after reset
    look(TA, "R1");
    look('0, "R1");

    // R5: old contents during the write cycle, new contents after the edge
    @(posedge clk); #1;
    wr_en = 1; wr_line = 0; wr_tag = TA; look_tag = TA;
    push_wait(TA, "R5 same cycle");
    @(posedge clk);
    mv[0] = 1; mt[0] = TA;
    #1 wr_en = 0;
    push_wait(TA, "R5 after edge");

    // R2: several lines, each found in its own cycle
    for (int k = 1; k < 4; k++) update(1, k, TAG_W'(22'h100 * k + 7), 0, 0);
    for (int k = 0; k < 4; k++) look(k == 0 ? TA : TAG_W'(22'h100 * k + 7), "R2");

    // R3: absent tag
    look(22'h2AAAAA, "R3");

    // R9: single-bit differences at both ends of the tag
    look(TA ^ 22'h000001, "R9 lsb");
    look(TA ^ 22'h200000, "R9 msb");

    // R7: lowest invalid line after four writes
    look(22'h2AAAAA, "R7 free 4");

    // R4: duplicate tag in line 6, lowest reported with multi flag
    update(1, 6, TAG_W'(22'h207), 0, 0);
    look(TAG_W'(22'h207), "R4 multi");

    // R6: invalidate line 2, line 6 now single match; free drops to 2
    update(0, 0, '0, 1, 2);
    look(TAG_W'(22'h207), "R6 drop dup");

    // R6: invalid line with matching tag does not hit
    update(0, 0, '0, 1, 0);
    look(TA, "R6 stale tag");

    // R8: write and invalidate on the same line and edge
    update(1, 0, TB, 1, 0);
    look(TB, "R8 write wins");

    // R8 companion: different lines, both take effect
    update(1, 2, TA, 1, 1);
    look(TA, "R8 split lines");
    look(TAG_W'(22'h107), "R8 split drop");

    // R7: fill every line, no free line left
    for (int k = 0; k < LINES; k++) update(1, k, TAG_W'(22'h3F0000 + k), 0, 0);
    look(TAG_W'(22'h3F0000 + LINES - 1), "R7 full hit last");
    look(TAG_W'(22'h3F0000), "R7 full hit first");

    // R1: reset mid-run clears everything
    do_reset();
    look(TAG_W'(22'h3F0005), "R1 second reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule